// File: doc/BRIEF.md
# Three-Channel Auto-Reload Timer Unit

This block groups up to three down-counting timers behind one simple register bus. Each timer counts down once per clock while it runs. When it reaches zero it loads its reload value again and raises a sticky underflow flag. Each timer drives its own interrupt line, which is the underflow flag gated by an enable bit. A single shared start register runs and stops all timers, one bit per timer. A separate one-bit output-control register drives an output pin.

Software reaches the block through byte offsets. The two shared registers sit at the bottom of the map, and each timer has a window of three 32-bit words. The windows sit at bases 0x08, 0x14 and 0x20. The third timer can be removed with a parameter. Any access that hits no register returns zero, changes nothing, and raises an error pulse in the next cycle.

Top module: `tmr_unit`

## Requirements
- R1: After reset, all timers are stopped, the start and output-control registers read 0, each timer's reload and count registers read 0xFFFFFFFF, its control register reads 0, and all interrupt lines are low.
- R2: Offset 0x00 is the output-control register. A write stores bit 0 only, and that bit drives `outCtl`. A read returns the stored bit in bit 0 with every other bit zero.
- R3: Offset 0x04 is the start register. While bit n is 1, timer n counts. A read returns the last value written, masked to the bits of the timers that are present.
- R4: Timer n's window starts at base 0x08 for n=0, 0x14 for n=1 and 0x20 for n=2. The window is decoded relative to its own base: +0x0 is reload, +0x4 is count, and +0x8 is control (bit 0 is the underflow flag, bit 1 is the interrupt enable). A write in one window leaves the other windows unchanged.
- R5: On every clock in which a timer runs, its count decreases by one. On a clock in which it runs with a count of zero, it loads its reload value and sets its underflow flag instead. The resulting period is reload+1 clocks.
- R6: A stopped timer holds its count.
- R7: Writing the control register with bit 0 = 0 clears the underflow flag, and writing bit 0 = 1 leaves the flag as it is. An underflow in the same clock as a clearing write wins.
- R8: `irq[n]` is high exactly while timer n's underflow flag and interrupt enable are both set. Each timer drives only its own line.
- R9: An access is invalid if its offset is unaligned, below 0x08 other than 0x00 and 0x04, or at byte +0xC or beyond inside the highest window. An invalid read returns 0. An invalid write changes no state. In both cases `busErr` is high for the one clock after the access.
- R10: With `HAS_CH2` = 0, every offset from 0x20 upward is invalid and `irq[2]` stays low. A start-register write with bit 2 set raises `busErr`, but bits 0 and 1 are still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWr | input | 1 | Write strobe, one access per cycle |
| busRd | input | 1 | Read strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from the address |
| busErr | output | 1 | One-cycle pulse after an invalid access |
| outCtl | output | 1 | Stored output-control bit |
| irq | output | 3 | Per-timer interrupt lines |

## Verification
A corrupted count or reload value changes the cycle on which the interrupt line rises. The directed tests therefore sample `irq` and the count register on exact clock edges. Any error of one or more cycles shows up within one timer period. A stuck or misrouted start bit shows up straight away: a stopped timer's count moves, or a running one's stays fixed. A wrong window decode lands a write in a neighbouring timer, and reading that timer back at once exposes it. A decode hole or overlap shows up on the next cycle as an unexpected or missing `busErr` pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MAX_CH = 3;
  localparam int WIN_BYTES = 12;
  localparam int OFF_OUT = 0;
  localparam int OFF_START = 4;
  localparam int FLAG_BIT = 0;
  localparam int IE_BIT = 1;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } chReg_e;

  typedef struct packed {
    logic wrReload;
    logic wrCount;
    logic wrCtrl;
    logic run;
  } chStrobe_t;

  function automatic int chBase(input int n);
    return 8 + WIN_BYTES * n;
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic                           busWr,
  input  logic                           busRd,
  input  logic [DATA_W-1:0]              busWdata,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chRdata,
  output logic [DATA_W-1:0]              busRdata,
  output logic                           busErr,
  output logic                           outCtl,
  output chReg_e                         regSel,
  output chStrobe_t [NUM_CH-1:0]         strobe
);
  localparam logic [MAX_CH-1:0] PRESENT = MAX_CH'((1 << NUM_CH) - 1);

  logic [NUM_CH-1:0] startQ;
  logic              outQ;
  logic              errQ;
  logic [1:0]        selCh;
  logic              inWin;
  logic [ADDR_W-1:0] relAddr;
  logic              aligned, chHit, outHit, startHit, badStart, badAcc;

  // decode: the highest base not above the address owns it
  always_comb begin
    selCh   = '0;
    inWin   = 1'b0;
    relAddr = '0;
    for (int n = 0; n < MAX_CH; n++) begin
      if (busAddr >= ADDR_W'(chBase(n))) begin
        selCh   = 2'(n);
        inWin   = 1'b1;
        relAddr = busAddr - ADDR_W'(chBase(n));
      end
    end
    aligned  = (busAddr[1:0] == 2'b00);
    chHit    = inWin && aligned && (int'(selCh) < NUM_CH) &&
               (relAddr < ADDR_W'(WIN_BYTES));
    outHit   = (busAddr == ADDR_W'(OFF_OUT));
    startHit = (busAddr == ADDR_W'(OFF_START));
    regSel   = chHit ? chReg_e'(relAddr[3:2]) : REG_NONE;
    badStart = busWr && startHit && |(busWdata[MAX_CH-1:0] & ~PRESENT);
    badAcc   = (busWr || busRd) && ((!chHit && !outHit && !startHit) || badStart);
  end

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_strobe
      logic mine;
      assign mine = busWr && chHit && (selCh == 2'(n));
      assign strobe[n].wrReload = mine && (regSel == REG_RELOAD);
      assign strobe[n].wrCount  = mine && (regSel == REG_COUNT);
      assign strobe[n].wrCtrl   = mine && (regSel == REG_CTRL);
      assign strobe[n].run      = startQ[n];
    end
  endgenerate

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      if (outHit) busRdata = DATA_W'(outQ);
      else if (startHit) busRdata = DATA_W'(startQ);
      else if (chHit) begin
        for (int n = 0; n < NUM_CH; n++)
          if (selCh == 2'(n)) busRdata = chRdata[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= '0;
      outQ   <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      errQ <= badAcc;
      if (busWr && outHit) outQ <= busWdata[0];
      if (busWr && startHit) startQ <= busWdata[NUM_CH-1:0];
    end
  end

  assign busErr = errQ;
  assign outCtl = outQ;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strobe,
  input  chReg_e            regSel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] reload,
  output logic              irq
);
  logic [DATA_W-1:0] countQ, reloadQ;
  logic              flagQ, ieQ, underflow;

  assign underflow = strobe.run && !strobe.wrCount && (countQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '1;
      reloadQ <= '1;
      flagQ   <= 1'b0;
      ieQ     <= 1'b0;
    end else begin
      if (strobe.wrReload) reloadQ <= wdata;
      if (strobe.wrCount) countQ <= wdata;
      else if (underflow) countQ <= reloadQ;
      else if (strobe.run) countQ <= countQ - 1'b1;
      if (strobe.wrCtrl) ieQ <= wdata[IE_BIT];
      if (underflow) flagQ <= 1'b1;
      else if (strobe.wrCtrl && !wdata[FLAG_BIT]) flagQ <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (regSel)
      REG_RELOAD: rdata = reloadQ;
      REG_COUNT:  rdata = countQ;
      REG_CTRL: begin
        rdata[FLAG_BIT] = flagQ;
        rdata[IE_BIT]   = ieQ;
      end
      default: rdata = '0;
    endcase
  end

  assign count  = countQ;
  assign reload = reloadQ;
  assign irq    = flagQ && ieQ;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter bit HAS_CH2 = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic              outCtl,
  output logic [2:0]        irq
);
  localparam int NUM_CH = HAS_CH2 ? MAX_CH : MAX_CH - 1;

  chStrobe_t [NUM_CH-1:0]         strobe;
  chReg_e                         regSel;
  logic [NUM_CH-1:0][DATA_W-1:0]  chRdata;
  logic [NUM_CH-1:0][DATA_W-1:0]  chCount;
  logic [NUM_CH-1:0][DATA_W-1:0]  chReload;
  logic [NUM_CH-1:0]              chRun;

  tmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .chRdata(chRdata), .busRdata(busRdata),
    .busErr(busErr), .outCtl(outCtl), .regSel(regSel), .strobe(strobe)
  );

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      tmr_channel #(.DATA_W(DATA_W)) u_ch (
        .clk(clk), .rstN(rstN), .strobe(strobe[n]), .regSel(regSel),
        .wdata(busWdata), .rdata(chRdata[n]), .count(chCount[n]),
        .reload(chReload[n]), .irq(irq[n])
      );
      assign chRun[n] = strobe[n].run;
    end
    if (NUM_CH < MAX_CH) begin : g_noCh2
      assign irq[MAX_CH-1] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter bit HAS_CH2 = 1'b1,
  localparam int NUM_CH = HAS_CH2 ? MAX_CH : MAX_CH - 1
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             busAddr,
  input logic                          busWr,
  input logic                          busRd,
  input logic [DATA_W-1:0]             busWdata,
  input logic                          busErr,
  input logic                          outCtl,
  input logic [2:0]                    irq,
  input logic [NUM_CH-1:0]             chRun,
  input logic [NUM_CH-1:0][DATA_W-1:0] chCount,
  input logic [NUM_CH-1:0][DATA_W-1:0] chReload
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (irq == 3'b000 && !outCtl));

  assert_outctl_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(OFF_OUT)) |=> (outCtl == $past(busWdata[0])));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busWr || busRd));

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      logic cntWr;
      assign cntWr = busWr && (busAddr == ADDR_W'(chBase(n) + 4));

      assert_reload_at_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
        (chRun[n] && chCount[n] == '0 && !cntWr) |=> (chCount[n] == $past(chReload[n])));

      assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rstN)
        (!chRun[n] && !cntWr) |=> $stable(chCount[n]));
    end
    if (!HAS_CH2) begin : g_noCh2
      assert_start_bit2_err_R10: assert property (@(posedge clk) disable iff (!rstN)
        (busWr && busAddr == ADDR_W'(OFF_START) && busWdata[2]) |=> busErr);
    end
  endgenerate
endmodule

bind tmr_unit tmr_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAS_CH2(HAS_CH2)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busErr(busErr), .outCtl(outCtl), .irq(irq),
  .chRun(chRun), .chCount(chCount), .chReload(chReload)
);

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdA, rdB;
  logic        errA, errB, outA, outB;
  logic [2:0]  irqA, irqB;
  int nChecks = 0;
  int nFails = 0;

  always #(PERIOD/2) clk = ~clk;

  tmr_unit dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(rdA), .busErr(errA), .outCtl(outA), .irq(irqA)
  );

  tmr_unit #(.HAS_CH2(1'b0)) dutNo2 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(rdB), .busErr(errB), .outCtl(outB), .irq(irqB)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] dA, output logic [31:0] dB);
    busAddr = a; busRd = 1'b1;
    #1;
    dA = rdA; dB = rdB;
    busRd = 1'b0;
  endtask

  task automatic rdClk(input logic [7:0] a, output logic [31:0] dA, output logic [31:0] dB);
    busAddr = a; busRd = 1'b1;
    #1;
    dA = rdA; dB = rdB;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] a, b;
    peek(8'h00, a, b); check("R1 outctl reg", a, 0);
    peek(8'h04, a, b); check("R1 start reg", a, 0);
    peek(8'h08, a, b); check("R1 ch0 reload", a, 32'hFFFF_FFFF);
    peek(8'h24, a, b); check("R1 ch2 count", a, 32'hFFFF_FFFF);
    peek(8'h1C, a, b); check("R1 ch1 ctrl", a, 0);
    check("R1 irq", 32'(irqA), 0);
  endtask

  task automatic testOutCtl();
    logic [31:0] a, b;
    wr(8'h00, 32'hFFFF_FFFF);
    peek(8'h00, a, b); check("R2 only bit0 stored", a, 1);
    check("R2 outCtl pin set", 32'(outA), 1);
    wr(8'h00, 32'h0000_0002);
    check("R2 outCtl pin clear", 32'(outA), 0);
  endtask

  task automatic testCount();
    logic [31:0] a, b;
    wr(8'h1C, 32'h2);
    wr(8'h18, 32'd3);
    wr(8'h14, 32'd5);
    wr(8'h04, 32'h2);
    repeat (3) @(negedge clk);
    peek(8'h18, a, b); check("R5 count reached zero", a, 0);
    check("R8 no irq before underflow", 32'(irqA), 0);
    peek(8'h0C, a, b); check("R3 ch0 not started holds", a, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 only ch1 irq", 32'(irqA), 32'h2);
    peek(8'h18, a, b); check("R5 reload at zero", a, 5);
    peek(8'h1C, a, b); check("R4 ch1 ctrl flag and enable", a, 3);
    wr(8'h1C, 32'h2);
    check("R7 clear flag", 32'(irqA), 0);
    repeat (4) @(negedge clk);
    check("R5 no irq one cycle early", 32'(irqA), 0);
    @(negedge clk);
    check("R5 period reload+1", 32'(irqA), 32'h2);
    wr(8'h1C, 32'h3);
    check("R7 writing one keeps flag", 32'(irqA), 32'h2);
    wr(8'h1C, 32'h1);
    check("R8 enable off drops irq", 32'(irqA), 0);
    peek(8'h1C, a, b); check("R8 flag kept while masked", a, 1);
    wr(8'h04, 32'h0);
    peek(8'h18, a, b); check("R6 count at stop", a, 2);
    repeat (5) @(negedge clk);
    peek(8'h18, a, b); check("R6 count held", a, 2);
  endtask

  task automatic testWindows();
    logic [31:0] a, b;
    wr(8'h24, 32'd7);
    peek(8'h24, a, b); check("R4 ch2 count", a, 7);
    peek(8'h0C, a, b); check("R4 ch0 untouched", a, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFF);
    check("R9 valid start write no error", 32'(errA), 0);
    peek(8'h04, a, b); check("R3 start masked full", a, 7);
    check("R10 start masked two channels", b, 3);
    check("R10 start bit2 error", 32'(errB), 1);
    wr(8'h04, 32'h0);
  endtask

  task automatic testErrors();
    logic [31:0] a, b;
    rdClk(8'h2C, a, b);
    check("R9 hole reads zero", a, 0);
    check("R9 error pulse", 32'(errA), 1);
    @(negedge clk);
    check("R9 error one cycle", 32'(errA), 0);
    wr(8'h01, 32'h1);
    check("R9 unaligned write error", 32'(errA), 1);
    check("R9 unaligned write ignored", 32'(outA), 0);
    rdClk(8'h08, a, b);
    check("R9 valid read no error", 32'(errA), 0);
    rdClk(8'h24, a, b);
    check("R10 absent window reads zero", b, 0);
    check("R10 absent window error", 32'(errB), 1);
    check("R10 present window no error", 32'(errA), 0);
    check("R10 irq2 low", 32'(irqB[2]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testOutCtl();
    testCount();
    testWindows();
    testErrors();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule